// File: doc/BRIEF.md
# Symbol Receiver with Idle-Line Detector

This block sits behind a spread-spectrum demodulator. It turns a stream of symbol decisions into a serial receive line for a host UART, and into a flag that tells the host when the shared medium has been quiet long enough to start a transmission. Each symbol period, a strobe comes in with a two-bit class. The class is a chirp of phase 1, a chirp of phase 2, or no carrier. A second strobe marks each host bit time, and the idle count is kept in these bit times. Both strobes come from timing logic outside the block.

During the packet body, a phase-1 chirp drives the receive line to MARK and a phase-2 chirp drives it to SPACE. Chirps heard while the upstream logic reports preamble leave the line alone. A chirp of either phase pulls the idle flag low at once. The flag returns high only after ten quiet host bit times, which gives every node the same settling time before the next contention round. The block follows the character framing so that it can find the end of a message. A phase-2 chirp outside a character is a start bit, and the character then spans 10 or 11 symbols, as set by a word-length input. A run of five phase-1 filler symbols between characters marks the end of the message, and the quiet count starts there.

Top module: `sym_rx_top`

## Requirements
- R1: While the active-low reset `rst_n` is low, `rx_line` and `idle_flag` are 1 and `char_done` and `msg_end` are 0. This holds immediately, without a clock edge, and also when reset is asserted in the middle of operation.
- R2: When `sym_stb` is high with `body_act`=1, class 2'b01 (phase 1) sets `rx_line` to 1 and class 2'b10 (phase 2) sets it to 0, at that clock edge.
- R3: A symbol of class 2'b00 (no carrier) or 2'b11 (reserved, treated as no carrier) sets `rx_line` to 1. It also abandons any character or filler run in progress.
- R4: A chirp (class 01 or 10) strobed with `body_act`=0 leaves `rx_line` unchanged. It also abandons any character or filler run in progress.
- R5: Any chirp, in preamble or body, clears `idle_flag` at that edge and restarts the quiet count from zero.
- R6: The quiet count begins at a no-carrier symbol (if the line was not already quiet) or at an end of message. `idle_flag` rises at the edge of the 10th `bit_stb` counted while quiet. A `bit_stb` in the same cycle as `sym_stb` is not counted.
- R7: Outside a character, in the body, five consecutive phase-1 chirps make `msg_end` a one-cycle pulse after the fifth. The line then counts as quiet from that edge.
- R8: In the body, a phase-2 chirp outside a character is a start bit. `word_len`=1 gives a 10-symbol character and `word_len`=0 gives an 11-symbol character, start and stop included. `char_done` pulses for one cycle after the last symbol of the character.
- R9: A start bit resets the filler run. Phase-1 symbols inside a character never count toward an end of message.
- R10: `word_len` is sampled at the start bit. Changing it in the middle of a character does not change that character's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_stb | input | 1 | One-cycle strobe per received symbol |
| sym_cls | input | 2 | Symbol class: 00 none, 01 phase 1, 10 phase 2, 11 reserved |
| body_act | input | 1 | 1 while the demodulator is in the packet body |
| bit_stb | input | 1 | One-cycle strobe per host bit time |
| word_len | input | 1 | 1 selects 8 data bits, 0 selects 9 |
| rx_line | output | 1 | Serial receive line to the host (1 = MARK) |
| idle_flag | output | 1 | 1 when the medium has been idle for 10 bit times |
| char_done | output | 1 | Pulse after the last symbol of a character |
| msg_end | output | 1 | Pulse after the fifth filler symbol of a message end |

## Verification
Every output is a register that takes its new value at the clock edge where the strobe is sampled, so each result is due exactly one edge after the stimulus. The one exception is reset, which acts with no edge at all. The bench drives strobes on the falling edge and holds them for exactly one rising edge. It compares all four outputs with its reference model on the following falling edge. An asynchronous reset is checked a few nanoseconds after `rst_n` falls, before any clock edge. The one-cycle pulses are also confirmed low at the step after they fire.

// File: rtl/sym_rx_pkg.sv
package sym_rx_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_PH1  = 2'b01,
    CLS_PH2  = 2'b10,
    CLS_RSVD = 2'b11
  } sym_cls_e;

  // Symbols per character: start + data + stop.
  function automatic int unsigned frame_symbols(input logic wl, input int unsigned data_short);
    return wl ? data_short + 2 : data_short + 3;
  endfunction

  function automatic logic carrier_present(input logic [1:0] cls);
    return (cls == CLS_PH1) || (cls == CLS_PH2);
  endfunction

endpackage

// File: rtl/sym_rx_decode.sv
module sym_rx_decode
  import sym_rx_pkg::*;
(
  input  logic       sym_stb,
  input  logic [1:0] sym_cls,
  input  logic       body_act,
  output logic       chirp_evt,
  output logic       none_evt,
  output logic       pre_evt,
  output logic       data_ph1,
  output logic       data_ph2
);

  always_comb begin
    chirp_evt = sym_stb && carrier_present(sym_cls);
    none_evt  = sym_stb && !carrier_present(sym_cls);
    pre_evt   = chirp_evt && !body_act;
    data_ph1  = chirp_evt && body_act && (sym_cls == CLS_PH1);
    data_ph2  = chirp_evt && body_act && (sym_cls == CLS_PH2);
  end

endmodule

// File: rtl/sym_rx_framer.sv
module sym_rx_framer
  import sym_rx_pkg::*;
#(
  parameter int unsigned DATA_SHORT = 8,
  parameter int unsigned STUFF_RUN  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic none_evt,
  input  logic pre_evt,
  input  logic data_ph1,
  input  logic data_ph2,
  input  logic word_len,
  output logic rx_line,
  output logic char_done,
  output logic msg_end,
  output logic eom_hit
);

  localparam int unsigned FRAME_MAX = DATA_SHORT + 3;
  localparam int unsigned PW = $clog2(FRAME_MAX + 1);
  localparam int unsigned SW = $clog2(STUFF_RUN + 1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] flen_q;
  logic [SW-1:0] stuff_q;
  logic          in_char;
  logic          last_sym;

  assign in_char  = (pos_q != '0);
  assign last_sym = in_char && (pos_q == PW'(flen_q - PW'(1)));
  assign eom_hit  = data_ph1 && !in_char && (stuff_q == SW'(STUFF_RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      flen_q    <= PW'(frame_symbols(1'b1, DATA_SHORT));
      stuff_q   <= '0;
      rx_line   <= 1'b1;
      char_done <= 1'b0;
      msg_end   <= 1'b0;
    end else begin
      char_done <= 1'b0;
      msg_end   <= 1'b0;
      if (none_evt) begin
        rx_line <= 1'b1;
        pos_q   <= '0;
        stuff_q <= '0;
      end else if (pre_evt) begin
        pos_q   <= '0;
        stuff_q <= '0;
      end else if (data_ph1 || data_ph2) begin
        rx_line <= data_ph1;
        if (in_char) begin
          if (last_sym) begin
            pos_q     <= '0;
            char_done <= 1'b1;
          end else begin
            pos_q <= pos_q + PW'(1);
          end
        end else if (data_ph2) begin
          pos_q   <= PW'(1);
          flen_q  <= PW'(frame_symbols(word_len, DATA_SHORT));
          stuff_q <= '0;
        end else if (eom_hit) begin
          stuff_q <= '0;
          msg_end <= 1'b1;
        end else begin
          stuff_q <= stuff_q + SW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sym_rx_idle.sv
module sym_rx_idle #(
  parameter int unsigned IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chirp_evt,
  input  logic none_evt,
  input  logic eom_hit,
  input  logic bit_stb,
  output logic line_quiet,
  output logic idle_flag
);

  localparam int unsigned CW = $clog2(IDLE_BITS + 1);

  logic [CW-1:0] cnt_q;
  logic          count_en;

  assign count_en = bit_stb && !chirp_evt && !none_evt && line_quiet
                    && (cnt_q < CW'(IDLE_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= CW'(IDLE_BITS);
      line_quiet <= 1'b1;
      idle_flag  <= 1'b1;
    end else if (chirp_evt) begin
      cnt_q      <= '0;
      line_quiet <= eom_hit;
      idle_flag  <= 1'b0;
    end else if (none_evt) begin
      if (!line_quiet) begin
        line_quiet <= 1'b1;
        cnt_q      <= '0;
      end
    end else if (count_en) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == CW'(IDLE_BITS - 1)) idle_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/sym_rx_top.sv
module sym_rx_top #(
  parameter int unsigned DATA_SHORT = 8,
  parameter int unsigned STUFF_RUN  = 5,
  parameter int unsigned IDLE_BITS  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_stb,
  input  logic [1:0] sym_cls,
  input  logic       body_act,
  input  logic       bit_stb,
  input  logic       word_len,
  output logic       rx_line,
  output logic       idle_flag,
  output logic       char_done,
  output logic       msg_end
);

  logic chirp_evt;
  logic none_evt;
  logic pre_evt;
  logic data_ph1;
  logic data_ph2;
  logic eom_hit;
  logic line_quiet;

  sym_rx_decode u_decode (
    .sym_stb  (sym_stb),
    .sym_cls  (sym_cls),
    .body_act (body_act),
    .chirp_evt(chirp_evt),
    .none_evt (none_evt),
    .pre_evt  (pre_evt),
    .data_ph1 (data_ph1),
    .data_ph2 (data_ph2)
  );

  sym_rx_framer #(.DATA_SHORT(DATA_SHORT), .STUFF_RUN(STUFF_RUN)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .none_evt (none_evt),
    .pre_evt  (pre_evt),
    .data_ph1 (data_ph1),
    .data_ph2 (data_ph2),
    .word_len (word_len),
    .rx_line  (rx_line),
    .char_done(char_done),
    .msg_end  (msg_end),
    .eom_hit  (eom_hit)
  );

  sym_rx_idle #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .chirp_evt (chirp_evt),
    .none_evt  (none_evt),
    .eom_hit   (eom_hit),
    .bit_stb   (bit_stb),
    .line_quiet(line_quiet),
    .idle_flag (idle_flag)
  );

endmodule

// File: rtl/sym_rx_chk.sv
module sym_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_stb,
  input logic [1:0] sym_cls,
  input logic       body_act,
  input logic       bit_stb,
  input logic       rx_line,
  input logic       idle_flag,
  input logic       char_done,
  input logic       msg_end,
  input logic       chirp_evt,
  input logic       eom_hit,
  input logic       line_quiet
);

  AST_CHIRP_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_evt |=> !idle_flag); // R5

  AST_NOCARRIER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !chirp_evt) |=> rx_line); // R3

  AST_PREAMBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chirp_evt && !body_act) |=> $stable(rx_line)); // R4

  AST_SPACE_ON_PH2: assert property (@(posedge clk) disable iff (!rst_n)
    (chirp_evt && body_act && sym_cls == 2'b10) |=> !rx_line); // R2

  AST_IDLE_RISE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> $past(bit_stb && !sym_stb && line_quiet)); // R6

  AST_EOM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eom_hit |=> (msg_end && line_quiet && !idle_flag)); // R7

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(char_done && msg_end)); // R9

endmodule

bind sym_rx_top sym_rx_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sym_stb   (sym_stb),
  .sym_cls   (sym_cls),
  .body_act  (body_act),
  .bit_stb   (bit_stb),
  .rx_line   (rx_line),
  .idle_flag (idle_flag),
  .char_done (char_done),
  .msg_end   (msg_end),
  .chirp_evt (chirp_evt),
  .eom_hit   (eom_hit),
  .line_quiet(line_quiet)
);

// File: tb/sym_rx_top_tb_top.sv
module sym_rx_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_stb = 1'b0;
  logic [1:0] sym_cls = 2'b00;
  logic       body_act = 1'b0;
  logic       bit_stb = 1'b0;
  logic       word_len = 1'b1;
  logic       rx_line, idle_flag, char_done, msg_end;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference state
  int m_pos, m_flen, m_stuff, m_cnt;
  bit m_quiet, m_ild, m_rx, m_done, m_end;

  always #10 clk = ~clk;

  sym_rx_top dut_i (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sym_cls(sym_cls),
    .body_act(body_act), .bit_stb(bit_stb), .word_len(word_len),
    .rx_line(rx_line), .idle_flag(idle_flag), .char_done(char_done), .msg_end(msg_end)
  );

  function automatic int char_len(input bit wl);
    return wl ? 10 : 11;
  endfunction

  task automatic model_reset();
    m_pos = 0; m_flen = 10; m_stuff = 0; m_cnt = 10;
    m_quiet = 1; m_ild = 1; m_rx = 1; m_done = 0; m_end = 0;
  endtask

  task automatic model_step(input bit s, input bit [1:0] c, input bit b, input bit bt, input bit wl);
    bit chirp, eom;
    m_done = 0; m_end = 0; eom = 0;
    chirp = s && (c == 2'b01 || c == 2'b10);
    if (s && !chirp) begin
      m_rx = 1; m_pos = 0; m_stuff = 0;
      if (!m_quiet) begin m_quiet = 1; m_cnt = 0; end
    end else if (chirp) begin
      m_ild = 0;
      if (!b) begin
        m_pos = 0; m_stuff = 0;
      end else begin
        m_rx = (c == 2'b01);
        if (m_pos == 0) begin
          if (c == 2'b10) begin m_pos = 1; m_flen = char_len(wl); m_stuff = 0; end
          else begin
            m_stuff++;
            if (m_stuff == 5) begin eom = 1; m_end = 1; m_stuff = 0; end
          end
        end else if (m_pos == m_flen - 1) begin
          m_pos = 0; m_done = 1;
        end else m_pos++;
      end
      m_quiet = eom; m_cnt = 0;
    end else if (bt && m_quiet && m_cnt < 10) begin
      m_cnt++;
      if (m_cnt == 10) m_ild = 1;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (rx_line !== m_rx || idle_flag !== m_ild || char_done !== m_done || msg_end !== m_end) begin
      fails++;
      $display("FAIL %s: rx/idle/done/end = %0b %0b %0b %0b, expected %0b %0b %0b %0b",
               tag, rx_line, idle_flag, char_done, msg_end, m_rx, m_ild, m_done, m_end);
    end
  endtask

  // Called at a falling edge; strobes stay high across exactly one rising edge.
  task automatic step(input bit s, input bit [1:0] c, input bit b, input bit bt,
                      input bit wl, input string tag);
    sym_stb = s; sym_cls = c; body_act = b; bit_stb = bt; word_len = wl;
    @(negedge clk);
    sym_stb = 0; bit_stb = 0;
    model_step(s, c, b, bt, wl);
    compare(tag);
  endtask

  task automatic sym(input bit [1:0] c, input bit b, input string tag);
    step(1, c, b, 0, word_len, tag);
  endtask

  task automatic bits(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 2'b00, body_act, 1, word_len, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd24681));
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after release");

    // R2: body polarity
    sym(2'b10, 1, "R2 phase-2 start gives SPACE");
    sym(2'b01, 1, "R2 phase-1 gives MARK");
    sym(2'b10, 1, "R2 phase-2 gives SPACE");
    // R4: preamble chirp keeps SPACE
    sym(2'b01, 0, "R4 preamble phase-1 holds line");
    sym(2'b10, 0, "R4 preamble phase-2 holds line");
    // R3: reserved class treated as no carrier
    sym(2'b10, 1, "R2 SPACE again");
    sym(2'b11, 1, "R3 reserved class gives MARK");
    sym(2'b10, 1, "R2 SPACE before none");
    sym(2'b00, 1, "R3 no carrier gives MARK");

    // R6: idle rises on the 10th counted bit
    bits(9, "R6 idle still low before 10th bit");
    step(1, 2'b00, 1, 1, 1, "R6 bit with symbol ignored");
    bits(1, "R6 idle rises on 10th bit");
    bits(2, "R6 idle saturates high");
    sym(2'b01, 0, "R5 preamble chirp clears idle");
    bits(4, "R5 chirp stops count");

    // R8: 10-symbol character, R10: word_len change mid-frame
    word_len = 1;
    sym(2'b10, 1, "R8 start bit");
    word_len = 0;
    for (int i = 0; i < 8; i++) sym((i % 3 == 0) ? 2'b01 : 2'b10, 1, "R10 data with word_len changed");
    sym(2'b01, 1, "R8 R10 stop ends 10-symbol char");
    sym(2'b01, 1, "R8 char_done cleared");
    // R8: 11-symbol character
    word_len = 0;
    sym(2'b10, 1, "R8 start long char");
    for (int i = 0; i < 9; i++) sym(2'b01, 1, "R9 phase-1 in char not filler");
    sym(2'b01, 1, "R8 stop ends 11-symbol char");

    // R9: filler run broken by start bit
    for (int i = 0; i < 3; i++) sym(2'b01, 1, "R9 filler run");
    word_len = 1;
    sym(2'b10, 1, "R9 start resets filler run");
    for (int i = 0; i < 9; i++) sym(2'b01, 1, "R8 char body");
    // R7: end of message
    for (int i = 0; i < 4; i++) sym(2'b01, 1, "R7 filler before end");
    sym(2'b01, 1, "R7 fifth filler ends message");
    sym(2'b01, 0, "R5 chirp after end clears quiet");
    for (int i = 0; i < 5; i++) sym(2'b01, 1, "R7 second end of message");
    bits(9, "R7 quiet count after end");
    bits(1, "R6 R7 idle rises after end");

    // R1: async reset mid-operation
    sym(2'b10, 1, "R2 SPACE before reset");
    rst_n = 0;
    #3;
    model_reset();
    compare("R1 async reset without clock");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 state after mid-run reset");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit s, b, bt, wl;
      bit [1:0] c;
      r  = $urandom_range(0, 99);
      s  = (r < 45);
      c  = ($urandom_range(0, 9) < 8) ? 2'($urandom_range(1, 2)) : 2'($urandom_range(0, 3));
      b  = ($urandom_range(0, 9) < 8);
      bt = ($urandom_range(0, 1) == 1);
      wl = ($urandom_range(0, 3) != 0);
      step(s, c, b, bt, wl, "R2 R3 R5 R6 R8 random mix");
    end
    finish_run();
  end

endmodule